// File: doc/BRIEF.md
# Digital Delta Modulation Encoder

This block turns a stream of signed digital samples into a one-bit-per-sample code. It keeps an internal staircase estimate of the signal. For every accepted sample it compares the sample with that estimate and emits a single bit. The bit is 1 when the sample lies above the estimate and 0 otherwise. The estimate then climbs or drops by one programmed step, so the bit stream alone is enough for a receiver to rebuild the same staircase.

The estimate saturates at the signed range limits instead of wrapping. There is no cap on how many equal bits may follow one another, so large signals that move slowly are still followed. A signal that moves faster than one step per sample cannot be followed. The block detects that case and raises a slope-overload flag. The cure is a larger step or a higher sample rate.

The step size is taken from its input only while the sample stream is quiet, so it never changes inside a burst. A small decoder that rebuilds the staircase from the emitted bits sits inside the block. A bound checker compares that decoder with the encoder's estimate.

Top module: `dm_encoder`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_bit` and `slope_ovl` are 0. After reset the estimate is 0, so a first sample of 0 gives bit 0 and a first sample of 1 gives bit 1.
- R2: For each accepted sample, `out_bit` is 1 exactly when the signed two's-complement sample is strictly greater than the current estimate, and 0 otherwise.
- R3: After a 1 the estimate rises by the step. After a 0 it falls by the step.
- R4: A constant input, once the estimate has reached it, produces a strictly alternating 1/0 bit pattern.
- R5: The estimate clamps at -2^(DW-1) and 2^(DW-1)-1 and never wraps.
- R6: Any number of consecutive equal bits may be emitted. A slow ramp to full scale yields an unbroken run of 1s.
- R7: `slope_ovl`, reported with each output bit, is 1 when two conditions hold: the current bit completes a run of at least RUN_LEN (default 4) equal bits, and the magnitude of (sample minus estimate before the update) exceeds the step. Otherwise it is 0.
- R8: `step_cfg` is loaded into the active step only on a clock edge where `in_valid` is low and was also low on the previous edge. Otherwise the active step is held.
- R9: `out_valid` is high for exactly the one clock after each edge on which `in_valid` was high, and is low after edges without a strobe. `out_bit` and `slope_ovl` hold their values between outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | DW | Signed input sample |
| step_cfg | input | SW | Unsigned step size, taken only while idle |
| out_valid | output | 1 | Output bit strobe, one clock after `in_valid` |
| out_bit | output | 1 | 1 = sample above estimate, 0 = not above |
| slope_ovl | output | 1 | Slope-overload indication for the current bit |

## Verification
A wrong estimate shows up at the ports on the very next sample, as a bit that differs from the one the requirements predict. On a constant input it shows as a broken alternating pattern. A wrong step or a step loaded mid-burst shifts the staircase, and the bit pattern diverges within two or three samples of the change. A wrong run counter shows as `slope_ovl` rising one sample early or late inside a long run. A wrap in place of saturation flips the bit polarity on the sample right after the limit is reached.

// File: rtl/dm_pkg.sv
`timescale 1ns/1ps
package dm_pkg;
  typedef enum logic {
    DM_DOWN = 1'b0,
    DM_UP   = 1'b1
  } dm_dir_e;
endpackage

// File: rtl/dm_stair_step.sv
`timescale 1ns/1ps
module dm_stair_step
  import dm_pkg::*;
#(
  parameter int DW = 12,
  parameter int SW = 11
) (
  input  logic signed [DW-1:0] est_i,
  input  logic        [SW-1:0] step_i,
  input  dm_dir_e              dir_i,
  output logic signed [DW-1:0] est_o
);
  localparam int XW = DW + 2;
  localparam logic signed [XW-1:0] HI = {3'b000, {(DW-1){1'b1}}};
  localparam logic signed [XW-1:0] LO = {3'b111, {(DW-1){1'b0}}};

  logic signed [XW-1:0] ext_est;
  logic signed [XW-1:0] ext_step;
  logic signed [XW-1:0] sum;

  always_comb begin
    ext_est  = {{2{est_i[DW-1]}}, est_i};
    ext_step = {{(XW-SW){1'b0}}, step_i};
    if (dir_i == DM_UP) sum = ext_est + ext_step;
    else                sum = ext_est - ext_step;
    if (sum > HI)      est_o = HI[DW-1:0];
    else if (sum < LO) est_o = LO[DW-1:0];
    else               est_o = sum[DW-1:0];
  end
endmodule

// File: rtl/dm_step_latch.sv
`timescale 1ns/1ps
module dm_step_latch #(
  parameter int SW = 11,
  parameter logic [SW-1:0] DEF_STEP = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [SW-1:0] step_cfg,
  output logic [SW-1:0] step_q
);
  logic          quiet_q;
  logic          load_en;
  logic [SW-1:0] step_d;

  always_comb begin
    load_en = !in_valid && quiet_q;
    step_d  = load_en ? step_cfg : step_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_q <= 1'b1;
      step_q  <= DEF_STEP;
    end else begin
      quiet_q <= !in_valid;
      step_q  <= step_d;
    end
  end
endmodule

// File: rtl/dm_run_tracker.sv
`timescale 1ns/1ps
module dm_run_tracker #(
  parameter int RUN_LEN = 4,
  localparam int CW = $clog2(RUN_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_en,
  input  logic          bit_i,
  output logic          run_full_o,
  output logic [CW-1:0] run_q
);
  localparam logic [CW-1:0] LIMIT = CW'(RUN_LEN);
  localparam logic [CW-1:0] ONE   = CW'(1);

  logic          last_q;
  logic [CW-1:0] run_nxt;
  logic [CW-1:0] run_d;
  logic          last_d;

  always_comb begin
    if (run_q != '0 && bit_i == last_q)
      run_nxt = (run_q == LIMIT) ? run_q : run_q + ONE;
    else
      run_nxt = ONE;
    run_full_o = (run_nxt == LIMIT);
    run_d      = smp_en ? run_nxt : run_q;
    last_d     = smp_en ? bit_i   : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      last_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      last_q <= last_d;
    end
  end
endmodule

// File: rtl/dm_decoder.sv
`timescale 1ns/1ps
module dm_decoder
  import dm_pkg::*;
#(
  parameter int DW = 12,
  parameter int SW = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_valid,
  input  logic                 bit_i,
  input  logic        [SW-1:0] step_i,
  output logic signed [DW-1:0] dec_est_o
);
  logic signed [DW-1:0] moved;
  logic signed [DW-1:0] est_d;

  dm_stair_step #(.DW(DW), .SW(SW)) u_step (
    .est_i (dec_est_o),
    .step_i(step_i),
    .dir_i (dm_dir_e'(bit_i)),
    .est_o (moved)
  );

  always_comb est_d = bit_valid ? moved : dec_est_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dec_est_o <= '0;
    else        dec_est_o <= est_d;
  end
endmodule

// File: rtl/dm_encoder.sv
`timescale 1ns/1ps
module dm_encoder
  import dm_pkg::*;
#(
  parameter int DW = 12,
  parameter int SW = DW - 1,
  parameter int RUN_LEN = 4,
  parameter logic [SW-1:0] DEF_STEP = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_sample,
  input  logic        [SW-1:0] step_cfg,
  output logic                 out_valid,
  output logic                 out_bit,
  output logic                 slope_ovl
);
  localparam int CW = $clog2(RUN_LEN + 1);

  // reset: asserted asynchronously, released after two clocks
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic        [SW-1:0] step_q;
  logic signed [DW-1:0] est_q;
  logic signed [DW-1:0] est_moved;
  logic signed [DW-1:0] est_d;
  logic signed [DW:0]   err_w;
  logic        [DW:0]   mag_w;
  logic        [DW:0]   step_ext;
  logic                 up_w;
  logic                 exceeds_w;
  logic                 run_full;
  logic        [CW-1:0] run_q;
  logic signed [DW-1:0] dec_est;
  logic                 vld_d;
  logic                 bit_d;
  logic                 ovl_d;

  dm_step_latch #(.SW(SW), .DEF_STEP(DEF_STEP)) u_step_latch (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .in_valid(in_valid),
    .step_cfg(step_cfg),
    .step_q  (step_q)
  );

  always_comb begin
    err_w     = $signed({in_sample[DW-1], in_sample}) - $signed({est_q[DW-1], est_q});
    up_w      = !err_w[DW] && (err_w != '0);
    mag_w     = err_w[DW] ? (-err_w) : err_w;
    step_ext  = {{(DW+1-SW){1'b0}}, step_q};
    exceeds_w = mag_w > step_ext;
  end

  dm_stair_step #(.DW(DW), .SW(SW)) u_stair (
    .est_i (est_q),
    .step_i(step_q),
    .dir_i (dm_dir_e'(up_w)),
    .est_o (est_moved)
  );

  dm_run_tracker #(.RUN_LEN(RUN_LEN)) u_run (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .smp_en    (in_valid),
    .bit_i     (up_w),
    .run_full_o(run_full),
    .run_q     (run_q)
  );

  // next state
  always_comb begin
    vld_d = in_valid;
    est_d = est_q;
    bit_d = out_bit;
    ovl_d = slope_ovl;
    if (in_valid) begin
      est_d = est_moved;
      bit_d = up_w;
      ovl_d = run_full && exceeds_w;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      est_q     <= '0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      slope_ovl <= 1'b0;
    end else begin
      est_q     <= est_d;
      out_valid <= vld_d;
      out_bit   <= bit_d;
      slope_ovl <= ovl_d;
    end
  end

  // reconstruction from the emitted bits, compared by the checker
  dm_decoder #(.DW(DW), .SW(SW)) u_dec (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bit_valid(out_valid),
    .bit_i    (out_bit),
    .step_i   (step_q),
    .dec_est_o(dec_est)
  );
endmodule

// File: rtl/dm_encoder_chk.sv
`timescale 1ns/1ps
module dm_encoder_chk #(
  parameter int DW = 12,
  parameter int SW = 11,
  parameter int RUN_LEN = 4,
  localparam int CW = $clog2(RUN_LEN + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic                 out_bit,
  input logic                 slope_ovl,
  input logic        [SW-1:0] step_q,
  input logic signed [DW-1:0] est_q,
  input logic signed [DW-1:0] dec_est,
  input logic        [CW-1:0] run_q
);
  p_strobe_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_step_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> $stable(step_q));

  p_dec_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> (dec_est == $past(est_q)));

  p_up_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_bit) |-> (est_q >= $past(est_q)));

  p_down_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_bit) |-> (est_q <= $past(est_q)));

  p_ovl_needs_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && slope_ovl) |-> (run_q == CW'(RUN_LEN)));
endmodule

bind dm_encoder dm_encoder_chk #(.DW(DW), .SW(SW), .RUN_LEN(RUN_LEN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .in_valid (in_valid),
  .out_valid(out_valid),
  .out_bit  (out_bit),
  .slope_ovl(slope_ovl),
  .step_q   (step_q),
  .est_q    (est_q),
  .dec_est  (dec_est),
  .run_q    (run_q)
);

// File: tb/dm_encoder_bench.sv
`timescale 1ns/1ps
module dm_encoder_bench;
  localparam int DW = 12;
  localparam int SW = 11;
  localparam int MAXV = 2047;
  localparam int MINV = -2048;
  localparam int RUNL = 4;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 in_valid;
  logic signed [DW-1:0] in_sample;
  logic        [SW-1:0] step_cfg;
  logic                 out_valid;
  logic                 out_bit;
  logic                 slope_ovl;

  int checks = 0;
  int errors = 0;

  // reference model state
  int est_m  = 0;
  int step_m = 16;
  int run_m  = 0;
  int last_m = 0;
  int prev_bit = 0;

  // table: sample, expected bit, expected overload (step 16, estimate 0)
  localparam int NV = 15;
  localparam int TV_IN  [NV] = '{0, 0, 100, 100, 100, 100, 100, 100, 100, 100, 100, -20, -20, -20, -20};
  localparam int TV_BIT [NV] = '{0, 1, 1,   1,   1,   1,   1,   1,   1,   0,   1,   0,   0,   0,   0};
  localparam int TV_OVL [NV] = '{0, 0, 0,   0,   1,   1,   1,   1,   0,   0,   0,   0,   0,   0,   1};

  dm_encoder #(.DW(DW), .SW(SW), .RUN_LEN(RUNL)) u_dm_encoder (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sample(in_sample),
    .step_cfg (step_cfg),
    .out_valid(out_valid),
    .out_bit  (out_bit),
    .slope_ovl(slope_ovl)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int model_step(input int smp);
    int up, aerr, ovl;
    up   = (smp > est_m) ? 1 : 0;
    aerr = (smp - est_m < 0) ? est_m - smp : smp - est_m;
    if (run_m != 0 && up == last_m) run_m = (run_m == RUNL) ? RUNL : run_m + 1;
    else                            run_m = 1;
    last_m = up;
    ovl = (run_m == RUNL && aerr > step_m) ? 1 : 0;
    est_m = up ? est_m + step_m : est_m - step_m;
    if (est_m > MAXV) est_m = MAXV;
    if (est_m < MINV) est_m = MINV;
    return 4 + up * 2 + ovl;
  endfunction

  task automatic drive_one(input int smp, output int got);
    in_valid  = 1'b1;
    in_sample = DW'(smp);
    @(negedge clk);
    got = {29'd0, out_valid, out_bit, slope_ovl};
    prev_bit = out_bit;
  endtask

  task automatic send(input int smp, input string tag);
    int exp, got;
    exp = model_step(smp);
    drive_one(smp, got);
    chk(tag, got, exp);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R9 out_valid low after strobe ends", {31'd0, out_valid}, 0);
    for (int i = 1; i < n; i++) @(negedge clk);
    if (n >= 2) step_m = step_cfg;
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 outputs zero in reset", {29'd0, out_valid, out_bit, slope_ovl}, 0);
    rst_n = 1'b1;
    est_m = 0; run_m = 0; last_m = 0;
    idle(5);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int got, cur, prv;
    in_valid = 1'b0;
    in_sample = '0;
    step_cfg = 11'd16;
    rst_n = 1'b0;
    @(negedge clk);
    do_reset();

    // R2 R3 R7: vector table walk
    for (int i = 0; i < NV; i++) begin
      void'(model_step(TV_IN[i]));
      drive_one(TV_IN[i], got);
      chk("R2 R3 R7 table vector", got, 4 + TV_BIT[i] * 2 + TV_OVL[i]);
    end
    idle(1);

    // R1: first sample after reset compares with zero
    do_reset();
    send(1, "R1 first sample 1 vs zero estimate");
    do_reset();
    send(0, "R1 first sample 0 vs zero estimate");

    // R4: constant input settles to alternation
    do_reset();
    prv = 0;
    for (int i = 0; i < 40; i++) begin
      send(300, "R4 constant input model");
      cur = prev_bit;
      if (i >= 30) chk("R4 alternating bits", cur, 1 - prv);
      prv = cur;
    end
    idle(2);

    // R6 R7: long slow climb, unbroken run of ones
    do_reset();
    for (int i = 0; i < 100; i++) begin
      send(MAXV, "R6 R7 long run");
      chk("R6 run of ones", prev_bit, 1);
    end
    idle(2);

    // R5: saturation at both limits with a large step
    step_cfg = 11'd1000;
    do_reset();
    for (int i = 0; i < 6; i++) send(MAXV, "R5 upper clamp");
    for (int i = 0; i < 8; i++) send(-2000, "R5 lower clamp");
    idle(2);

    // R8: step change mid-stream ignored, taken after two idle edges
    step_cfg = 11'd16;
    do_reset();
    send(1000, "R8 before change");
    step_cfg = 11'd200;
    idle(1);
    send(30, "R8 one-cycle gap keeps old step");
    send(40, "R8 old step still active");
    idle(2);
    send(1000, "R8 new step after idle");
    send(100, "R8 new step applied");
    idle(1);

    // R1: asynchronous reset in the middle of a stream
    step_cfg = 11'd16;
    send(500, "R1 stream before reset");
    send(500, "R1 stream before reset");
    #2 rst_n = 1'b0;
    #1 chk("R1 async clear", {29'd0, out_valid, out_bit, slope_ovl}, 0);
    @(negedge clk);
    in_valid = 1'b0;
    do_reset();
    send(0, "R1 estimate zero after reset");
    send(0, "R3 step down then up");
    idle(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule